// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by N = 32·M + S and emits one comparison pulse, one input cycle wide, per N input cycles. It sits in the feedback path of a frequency synthesizer. The pulse it produces is compared against a reference-derived pulse by a phase detector elsewhere in the chip.

Internally, a small prescaler divides by 33 or by 32 under a modulus select. A 5-bit swallow counter keeps the prescaler at 33 for the first S prescaler periods. A 12-bit main counter ends the output period after M prescaler periods. The total is 33·S + 32·(M − S) = 32·M + S input cycles.

The main and swallow values come from an external control latch. The divider samples them only at an output period boundary, so a period is never built from a mix of old and new settings. A standby input holds every counter cleared. The prescaler runs synchronously on the same clock as the two counters.

Top module: `pulse_swallow_div`

## Requirements
- R1: With settings M (main_i) and S (swal_i) active, `pulse_o` is high after every N-th rising clock edge, where N = 32·M + S = {main_i, swal_i} read as one 17-bit number. The first pulse follows the N-th edge after reset or standby is released.
- R2: Each `pulse_o` assertion lasts exactly one clock cycle.
- R3: `modsel_o` is high (divide-by-33) during the first 33·S cycles of every output period and low for the remaining 32·(M − S) cycles. When S = 0 it never goes high.
- R4: `main_i` and `swal_i` are sampled only at the first active edge after reset or standby, and at the edge that raises `pulse_o`. A change at any other time has no effect on the period in progress.
- R5: While `standby_i` is high, `pulse_o` and `modsel_o` stay low and all counting is held cleared. After release, a full period counted from the release edge elapses before the next pulse.
- R6: While `rst_n` is low, `pulse_o` and `modsel_o` are low.
- R7: M = 314, S = 4 yields a pulse every 10052 cycles.
- R8: The boundary settings M = 32, S = 0 (N = 1024) and M = 33, S = 31 (N = 1087) divide exactly. Valid settings satisfy 32 ≤ M ≤ 4095, 0 ≤ S ≤ 31 and M > S.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | High holds the divider cleared |
| main_i | input | 12 | Main count M from the control latch |
| swal_i | input | 5 | Swallow count S from the control latch |
| pulse_o | output | 1 | One-cycle comparison pulse per N input cycles |
| modsel_o | output | 1 | Prescaler modulus select, high for divide-by-33 |

## Verification
The bench targets three corner cases.

- **Period boundaries.** A divider whose prescaler wraps one count early or late gives periods that are off by M or by S. An off-by-one in the main-counter compare shifts every pulse by 32 or 33 cycles.
- **Settings changed mid-period.** A design that reads the inputs continuously would shorten or stretch the period in progress. Its pulse would then drift from the reference model within the same period.
- **Extreme swallow values and standby.** S = 0 catches a modulus select that goes high for even one prescaler cycle. S = 31 with M = 33 catches a swallow counter that saturates or overruns. Standby taken mid-period catches a divider that resumes from its old count instead of restarting.

// File: rtl/psd_pkg.sv
package psd_pkg;

    typedef enum logic {
        MOD_BASE  = 1'b0,
        MOD_PLUS1 = 1'b1
    } modulus_e;

endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
#(
    parameter int SWAL_W = 5
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clear_i,
    input  modulus_e modulus_i,
    output logic     wrap_o
);
    localparam int BASE = 1 << SWAL_W;
    localparam int PC_W = SWAL_W + 1;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d = st_q;
        if (modulus_i == MOD_PLUS1) begin
            wrap = (st_q.pc == PC_W'(BASE));
        end else begin
            wrap = (st_q.pc == PC_W'(BASE - 1));
        end
        if (clear_i || wrap) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = st_q.pc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wrap_o = wrap && !clear_i;

endmodule

// File: rtl/psd_swallow_ctrl.sv
module psd_swallow_ctrl
    import psd_pkg::*;
#(
    parameter int MAIN_W = 12,
    parameter int SWAL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              wrap_i,
    input  logic [MAIN_W-1:0] main_i,
    input  logic [SWAL_W-1:0] swal_i,
    output modulus_e          modulus_o,
    output logic              last_o
);
    typedef struct packed {
        logic              fresh;
        logic [MAIN_W-1:0] m;
        logic [SWAL_W-1:0] s;
        logic [MAIN_W-1:0] mc;
        logic [SWAL_W-1:0] sc;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic       plus1;
    logic       last;

    always_comb begin
        plus1 = (st_q.sc < st_q.s);
        last  = wrap_i && !st_q.fresh && (st_q.mc == st_q.m - 1'b1);
        st_d  = st_q;
        if (clear_i) begin
            st_d       = '0;
            st_d.fresh = 1'b1;
        end else if (st_q.fresh) begin
            st_d.fresh = 1'b0;
            st_d.m     = main_i;
            st_d.s     = swal_i;
        end else if (last) begin
            st_d.m  = main_i;
            st_d.s  = swal_i;
            st_d.mc = '0;
            st_d.sc = '0;
        end else if (wrap_i) begin
            st_d.mc = st_q.mc + 1'b1;
            if (plus1) begin
                st_d.sc = st_q.sc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.fresh <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign modulus_o = plus1 ? MOD_PLUS1 : MOD_BASE;
    assign last_o    = last;

endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int MAIN_W = 12,
    parameter int SWAL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              standby_i,
    input  logic [MAIN_W-1:0] main_i,
    input  logic [SWAL_W-1:0] swal_i,
    output logic              pulse_o,
    output logic              modsel_o
);
    typedef struct packed {
        logic pulse;
    } out_state_t;

    out_state_t st_d, st_q;
    modulus_e   modulus;
    logic       wrap;
    logic       last;

    psd_prescaler #(
        .SWAL_W (SWAL_W)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (standby_i),
        .modulus_i (modulus),
        .wrap_o    (wrap)
    );

    psd_swallow_ctrl #(
        .MAIN_W (MAIN_W),
        .SWAL_W (SWAL_W)
    ) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (standby_i),
        .wrap_i    (wrap),
        .main_i    (main_i),
        .swal_i    (swal_i),
        .modulus_o (modulus),
        .last_o    (last)
    );

    always_comb begin
        st_d.pulse = last && !standby_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o  = st_q.pulse;
    assign modsel_o = (modulus == MOD_PLUS1);

endmodule

// File: rtl/psd_checker.sv
module psd_checker #(
    parameter int MAIN_W = 12,
    parameter int SWAL_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              standby_i,
    input logic [MAIN_W-1:0] main_i,
    input logic [SWAL_W-1:0] swal_i,
    input logic              pulse_o,
    input logic              modsel_o
);
    localparam int NW = MAIN_W + SWAL_W + 1;

    logic          fresh_q;
    logic          exp_q;
    logic [NW-1:0] cnt_q;
    logic [NW-1:0] n_q;

    // independent period counter: edges since period start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fresh_q <= 1'b1;
            exp_q   <= 1'b0;
            cnt_q   <= '0;
            n_q     <= '0;
        end else if (standby_i) begin
            fresh_q <= 1'b1;
            exp_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (fresh_q) begin
            fresh_q <= 1'b0;
            exp_q   <= 1'b0;
            cnt_q   <= NW'(1);
            n_q     <= NW'({main_i, swal_i});
        end else if (cnt_q + 1'b1 == n_q) begin
            exp_q <= 1'b1;
            cnt_q <= '0;
            n_q   <= NW'({main_i, swal_i});
        end else begin
            exp_q <= 1'b0;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o == exp_q);

    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    p_mod_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(modsel_o) |-> (pulse_o || $past(standby_i) || $past(fresh_q)));

    p_standby_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        standby_i |=> (!pulse_o && !modsel_o));

endmodule

bind pulse_swallow_div psd_checker #(
    .MAIN_W (MAIN_W),
    .SWAL_W (SWAL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_i),
    .main_i    (main_i),
    .swal_i    (swal_i),
    .pulse_o   (pulse_o),
    .modsel_o  (modsel_o)
);

// File: tb/sim_pulse_swallow_div.sv
module sim_pulse_swallow_div;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        standby_i;
    logic [11:0] main_i;
    logic [4:0]  swal_i;
    logic        pulse_o;
    logic        modsel_o;

    int    checks = 0;
    int    fails  = 0;
    string req    = "R6";
    bit    done   = 1'b0;

    // reference model state
    bit     m_fresh = 1'b1;
    int     m_cnt   = 0;
    int     m_n     = 0;
    int     m_s     = 0;
    bit     m_pulse = 1'b0;
    int     pulses  = 0;
    bit     prev_pulse = 1'b0;

    pulse_swallow_div u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .main_i    (main_i),
        .swal_i    (swal_i),
        .pulse_o   (pulse_o),
        .modsel_o  (modsel_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || standby_i) begin
            m_fresh = 1'b1;
            m_cnt   = 0;
            m_pulse = 1'b0;
        end else if (m_fresh) begin
            m_fresh = 1'b0;
            m_n     = 32 * int'(main_i) + int'(swal_i);
            m_s     = int'(swal_i);
            m_cnt   = 1;
            m_pulse = 1'b0;
        end else begin
            m_cnt = m_cnt + 1;
            if (m_cnt == m_n) begin
                m_pulse = 1'b1;
                m_cnt   = 0;
                m_n     = 32 * int'(main_i) + int'(swal_i);
                m_s     = int'(swal_i);
                pulses  = pulses + 1;
            end else begin
                m_pulse = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare against the model on every clock, away from the rising edge
    always @(negedge clk) begin
        if (!done) begin
            check(req, int'(pulse_o), int'(m_pulse));
            check((req == "R6" || req == "R5") ? req : "R3", int'(modsel_o),
                  int'(!m_fresh && (m_cnt < 33 * m_s)));
            if (prev_pulse) check("R2", int'(pulse_o), 0);
            prev_pulse = pulse_o;
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int base;
        rst_n     = 1'b0;
        standby_i = 1'b0;
        main_i    = 12'd314;
        swal_i    = 5'd4;
        req       = "R6";
        cycles(4);
        rst_n = 1'b1;
        req   = "R7";
        base  = pulses;
        cycles(2 * 10052 + 5);
        check("R7", pulses - base, 2);

        main_i = 12'd32;
        swal_i = 5'd0;
        req    = "R8";
        cycles(10052 + 3 * 1024 + 10);
        main_i = 12'd33;
        swal_i = 5'd31;
        cycles(1024 + 3 * 1087 + 10);

        req    = "R4";
        main_i = 12'd40;
        swal_i = 5'd7;
        cycles(1087 + 700);
        main_i = 12'd50;
        swal_i = 5'd3;
        cycles(1287 + 2 * 1603 + 10);

        req       = "R5";
        cycles(500);
        standby_i = 1'b1;
        main_i    = 12'd45;
        swal_i    = 5'd9;
        cycles(100);
        standby_i = 1'b0;
        req       = "R1";
        base      = pulses;
        cycles(3 * 1449 + 5);
        check("R1", pulses - base, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule